// File: doc/BRIEF.md
# Dot-Matrix LCD Scan Controller

This block drives the timing side of a dot-matrix liquid-crystal panel of up to 16 common lines and 32 segment lines. Each pulse on the slot strobe opens a new time slot in which one common line is selected and the 32 segment lines carry the dot pattern of that common's row, taken from a display RAM. The block does not make analog levels. Every pin gets a small digital drive code, and an external level generator turns that code into the matching bias voltage.

The number of scanned commons is programmable from one to sixteen. The waveform polarity flips at every frame start, so the panel sees AC drive. A display-mode input can override the RAM: all dots lit, all dots dark, or a power-down state in which every pin sits at ground and the RAM is left idle. The bias-ratio choice is passed through to the level generator as a registered configuration output.

The block reads a row ahead of time. While one slot is on display, the row for the next slot is fetched into a prefetch register. At the slot strobe, that register moves into the display latch.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: During reset, and after reset until the first slot strobe, every common and segment drive code is 3'b000 (ground) and `biasFive` is 0.
- R2: A drive code is {driven, select, polarity} in bits {2,1,0}. In a running slot, exactly one common has the select bit set. That common is the one scheduled for the slot, and successive slots step the common index 0, 1, ... up to the active count minus one, then wrap to 0.
- R3: `dutyCfg` holds the number of scanned commons minus one (0 gives 1/1, 15 gives 1/16). A new value is taken only at the slot that starts a frame (common 0). Commons above the active count are never selected.
- R4: The polarity bit of all pins inverts at every frame start. The first frame after reset or after power-down has polarity 0.
- R5: In normal mode (`dispMode` = 0), segment j carries the select bit exactly when bit j of the RAM word for the current common is 1.
- R6: In all-on mode (`dispMode` = 1), every segment is selected. In all-off mode (`dispMode` = 2), every segment is non-selected. In both modes the RAM contents have no effect, and the commons keep scanning.
- R7: In power-down mode (`dispMode` = 3), every drive code is 3'b000, `ramRdEn` stays low, and slot strobes are ignored. On leaving power-down, the next slot starts a fresh frame at common 0.
- R8: One cycle after a slot strobe, the block issues a single read with `ramAddr` = (next common) * 32. The 32-bit word returned in the following cycle (bit j = segment j) is shown in the next slot. Slot strobes must be at least 3 cycles apart.
- R9: `biasFive` follows `biasSel` one clock later (1 = 1/5 bias, 0 = 1/4 bias).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | One-cycle strobe that starts a time slot |
| dutyCfg | input | 4 | Scanned commons minus one |
| dispMode | input | 2 | 0 normal, 1 all-on, 2 all-off, 3 power-down |
| biasSel | input | 1 | Bias ratio choice |
| ramRdEn | output | 1 | Display RAM read enable |
| ramAddr | output | 9 | Display RAM row base address |
| ramRdData | input | 32 | Row word, valid the cycle after a read |
| comDrive | output | 48 | Common drive codes, 3 bits per pin, pin i at [3i+2:3i] |
| segDrive | output | 96 | Segment drive codes, 3 bits per pin, pin j at [3j+2:3j] |
| biasFive | output | 1 | Registered bias choice for the level generator |

## Verification
The scan is run with full sixteen-common duty over more than one frame. This separates the frame-wide polarity flip from the per-slot common step. A duty change made in the middle of a frame shows whether the new count waits for the frame boundary. Duty 1/1 checks the case where every slot is a frame. Each RAM row holds a distinct pattern, so the bench can tell a wrong row, a stale prefetch or a bit-order error from correct data. All-on and all-off are run over those same nonzero rows to show that the RAM is overridden. Power-down is entered in the middle of a scan and then left again, which shows the ground codes, the silent RAM port and the clean restart at common 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL     = 2'd0,
    MODE_ALL_ON     = 2'd1,
    MODE_ALL_OFF    = 2'd2,
    MODE_POWER_DOWN = 2'd3
  } dispMode_e;

  // Per-pin drive code: bit 2 driven, bit 1 select, bit 0 frame polarity.
  localparam int CODE_W = 3;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic slotLoad;    // prefetched row moves into the display latch
    logic rowCapture;  // RAM word is valid, capture into the prefetch register
    logic scanIdle;    // power-down: clear the display latch
  } scanStrobe_t;

endpackage

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 32,
  localparam int COM_W  = $clog2(NUM_COM),
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int ADDR_W = COM_W + SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotTick,
  input  logic [COM_W-1:0]  dutyCfg,
  input  logic              powerDown,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [COM_W-1:0]  curCom,
  output logic [COM_W-1:0]  activeLast,
  output logic              framePol,
  output logic              scanRun,
  output scanStrobe_t       strobe
);

  logic [COM_W-1:0] pfCom;      // common whose row is prefetched for the next slot
  logic [COM_W-1:0] lastNew;
  logic             fetchDue;
  logic             rdValid;
  logic             frameStart;

  assign frameStart = (pfCom == '0);
  assign lastNew    = frameStart ? dutyCfg : activeLast;
  assign ramRdEn    = fetchDue && !powerDown;
  assign ramAddr    = {pfCom, {SEG_W{1'b0}}};

  always_comb begin
    strobe            = '0;
    strobe.slotLoad   = slotTick && !powerDown;
    strobe.rowCapture = rdValid;
    strobe.scanIdle   = powerDown;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfCom      <= '0;
      curCom     <= '0;
      activeLast <= '0;
      framePol   <= 1'b0;
      scanRun    <= 1'b0;
      fetchDue   <= 1'b1;
      rdValid    <= 1'b0;
    end else if (powerDown) begin
      pfCom    <= '0;
      curCom   <= '0;
      framePol <= 1'b0;
      scanRun  <= 1'b0;
      fetchDue <= 1'b1;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= ramRdEn;
      if (ramRdEn) fetchDue <= 1'b0;
      if (slotTick) begin
        curCom     <= pfCom;
        activeLast <= lastNew;
        pfCom      <= (pfCom == lastNew) ? '0 : pfCom + COM_W'(1);
        scanRun    <= 1'b1;
        fetchDue   <= 1'b1;
        if (frameStart) framePol <= scanRun ? ~framePol : 1'b0;
      end
    end
  end

endmodule

// File: rtl/lcd_scan_drv.sv
module lcd_scan_drv
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 32,
  localparam int COM_W  = $clog2(NUM_COM)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  scanStrobe_t                 strobe,
  input  logic [NUM_SEG-1:0]          ramRdData,
  input  logic [COM_W-1:0]            curCom,
  input  logic                        framePol,
  input  logic                        scanRun,
  input  dispMode_e                   mode,
  output logic [NUM_COM*CODE_W-1:0]   comDrive,
  output logic [NUM_SEG*CODE_W-1:0]   segDrive
);

  logic [NUM_SEG-1:0] prefetchRow;
  logic [NUM_SEG-1:0] rowLatch;
  logic [NUM_SEG-1:0] segSel;
  logic               driven;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefetchRow <= '0;
      rowLatch    <= '0;
    end else begin
      if (strobe.rowCapture) prefetchRow <= ramRdData;
      if (strobe.scanIdle)      rowLatch <= '0;
      else if (strobe.slotLoad) rowLatch <= prefetchRow;
    end
  end

  assign driven = scanRun && (mode != MODE_POWER_DOWN);

  always_comb begin
    unique case (mode)
      MODE_ALL_ON:  segSel = '1;
      MODE_ALL_OFF: segSel = '0;
      default:      segSel = rowLatch;
    endcase
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign comDrive[i*CODE_W +: CODE_W] =
      driven ? {1'b1, (curCom == COM_W'(i)), framePol} : '0;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    assign segDrive[j*CODE_W +: CODE_W] =
      driven ? {1'b1, segSel[j], framePol} : '0;
  end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 32,
  localparam int COM_W  = $clog2(NUM_COM),
  localparam int ADDR_W = COM_W + $clog2(NUM_SEG)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      slotTick,
  input  logic [COM_W-1:0]          dutyCfg,
  input  logic [1:0]                dispMode,
  input  logic                      biasSel,
  output logic                      ramRdEn,
  output logic [ADDR_W-1:0]         ramAddr,
  input  logic [NUM_SEG-1:0]        ramRdData,
  output logic [NUM_COM*CODE_W-1:0] comDrive,
  output logic [NUM_SEG*CODE_W-1:0] segDrive,
  output logic                      biasFive
);

  dispMode_e        mode;
  scanStrobe_t      strobe;
  logic [COM_W-1:0] curCom;
  logic [COM_W-1:0] activeLast;
  logic             framePol;
  logic             scanRun;

  assign mode = dispMode_e'(dispMode);

  always_ff @(posedge clk) begin
    if (!rstN) biasFive <= 1'b0;
    else       biasFive <= biasSel;
  end

  lcd_scan_seq #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .slotTick   (slotTick),
    .dutyCfg    (dutyCfg),
    .powerDown  (mode == MODE_POWER_DOWN),
    .ramRdEn    (ramRdEn),
    .ramAddr    (ramAddr),
    .curCom     (curCom),
    .activeLast (activeLast),
    .framePol   (framePol),
    .scanRun    (scanRun),
    .strobe     (strobe)
  );

  lcd_scan_drv #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_drv (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ramRdData (ramRdData),
    .curCom    (curCom),
    .framePol  (framePol),
    .scanRun   (scanRun),
    .mode      (mode),
    .comDrive  (comDrive),
    .segDrive  (segDrive)
  );

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COM = 16,
  parameter int NUM_SEG = 32,
  localparam int COM_W  = $clog2(NUM_COM)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [1:0]                dispMode,
  input logic                      ramRdEn,
  input logic [NUM_COM*CODE_W-1:0] comDrive,
  input logic [NUM_SEG*CODE_W-1:0] segDrive,
  input logic [COM_W-1:0]          curCom,
  input logic [COM_W-1:0]          activeLast,
  input logic                      framePol,
  input logic                      scanRun
);

  logic [NUM_COM-1:0] comSelBits;

  always_comb begin
    for (int i = 0; i < NUM_COM; i++) comSelBits[i] = comDrive[i*CODE_W + 1];
  end

  p_single_com_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSelBits));

  p_com_within_duty_r3: assert property (@(posedge clk) disable iff (!rstN)
    scanRun |-> (curCom <= activeLast));

  p_pol_at_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scanRun && $past(scanRun) && !$stable(framePol)) |-> (curCom == '0));

  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dispMode == 2'd3) |-> (!ramRdEn && comDrive == '0 && segDrive == '0));

  p_read_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |=> !ramRdEn);

endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dispMode   (dispMode),
  .ramRdEn    (ramRdEn),
  .comDrive   (comDrive),
  .segDrive   (segDrive),
  .curCom     (curCom),
  .activeLast (activeLast),
  .framePol   (framePol),
  .scanRun    (scanRun)
);

// File: tb/sim_lcd_scan_ctrl.sv
module sim_lcd_scan_ctrl;

  localparam int NC = 16;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slotTick = 1'b0;
  logic [3:0]    dutyCfg = 4'd15;
  logic [1:0]    dispMode = 2'd0;
  logic          biasSel = 1'b0;
  logic          ramRdEn;
  logic [8:0]    ramAddr;
  logic [31:0]   ramRdData = '0;
  logic [47:0]   comDrive;
  logic [95:0]   segDrive;
  logic          biasFive;

  logic [31:0]   rows [NC];

  typedef struct {
    logic [47:0] com;
    logic [95:0] seg;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;
  int pdReads = 0;
  bit done = 0;

  // bench model of the scan
  int bNext = 0, bLast = 0;
  bit bPol = 0, bRun = 0;

  always #5 clk = ~clk;

  lcd_scan_ctrl u0 (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .dutyCfg(dutyCfg),
    .dispMode(dispMode), .biasSel(biasSel), .ramRdEn(ramRdEn),
    .ramAddr(ramAddr), .ramRdData(ramRdData), .comDrive(comDrive),
    .segDrive(segDrive), .biasFive(biasFive)
  );

  always @(posedge clk) if (ramRdEn) ramRdData <= rows[ramAddr >> 5];

  task automatic check(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (dispMode == 2'd3 && ramRdEn) pdReads++;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(comDrive == e.com, {e.tag, " com"}, {48'd0, comDrive}, {48'd0, e.com});
      check(segDrive == e.seg, {e.tag, " seg"}, segDrive, e.seg);
    end
  end

  task automatic tick();
    exp_t e;
    int cur;
    @(negedge clk);
    slotTick = 1'b1;
    e.com = '0;
    e.seg = '0;
    e.tag = "R2 R5 R6 R7 slot";
    if (dispMode != 2'd3) begin
      cur = bNext;
      if (cur == 0) begin
        bPol  = bRun ? ~bPol : 1'b0;   // R4
        bLast = int'(dutyCfg);         // R3
      end
      bRun  = 1'b1;
      bNext = (cur == bLast) ? 0 : cur + 1;
      for (int i = 0; i < NC; i++) e.com[i*3 +: 3] = {1'b1, (i == cur), bPol};
      for (int j = 0; j < NS; j++) begin
        bit s;
        case (dispMode)
          2'd1:    s = 1'b1;
          2'd2:    s = 1'b0;
          default: s = rows[cur][j];
        endcase
        e.seg[j*3 +: 3] = {1'b1, s, bPol};
      end
    end
    #1 expQ.push_back(e);
    @(negedge clk);
    slotTick = 1'b0;
    if (dispMode != 2'd3) begin
      check(ramRdEn == 1'b1, "R8 read issued", {95'd0, ramRdEn}, 96'd1);
      check(ramAddr == 9'(bNext * 32), "R8 read address", {87'd0, ramAddr},
            96'(bNext * 32));
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    dispMode = m;
    if (m == 2'd3) begin
      bRun  = 1'b0;
      bNext = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++)
      rows[i] = (32'h1 << i) ^ (32'h9E37_79B9 * (i + 1)) ^ {i[3:0], 28'h0};

    repeat (4) @(negedge clk);
    check(comDrive == '0 && segDrive == '0, "R1 ground in reset",
          {48'd0, comDrive}, 96'd0);
    check(biasFive == 1'b0, "R1 bias reset", {95'd0, biasFive}, 96'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(comDrive == '0 && segDrive == '0, "R1 ground before first slot",
          segDrive, 96'd0);

    // R2 R4 R5: full duty over more than a frame
    dutyCfg = 4'd15;
    for (int k = 0; k < 20; k++) tick();

    // R3: shorten duty mid-frame, new count waits for the boundary
    dutyCfg = 4'd3;
    for (int k = 0; k < 24; k++) tick();

    // R3 R4: 1/1 duty, each slot is a frame
    dutyCfg = 4'd0;
    for (int k = 0; k < 5; k++) tick();

    // R6: overrides over nonzero RAM rows
    dutyCfg = 4'd2;
    setMode(2'd1);
    for (int k = 0; k < 6; k++) tick();
    setMode(2'd2);
    for (int k = 0; k < 6; k++) tick();

    // R7: power-down mid-scan, then restart at common 0
    setMode(2'd0);
    for (int k = 0; k < 2; k++) tick();
    setMode(2'd3);
    check(comDrive == '0 && segDrive == '0, "R7 ground in power-down",
          segDrive, 96'd0);
    for (int k = 0; k < 3; k++) tick();
    check(pdReads == 0, "R7 no RAM reads", 96'(pdReads), 96'd0);
    setMode(2'd0);
    for (int k = 0; k < 7; k++) tick();

    // R9: bias export
    @(negedge clk);
    biasSel = 1'b1;
    @(negedge clk);
    check(biasFive == 1'b1, "R9 bias high", {95'd0, biasFive}, 96'd1);
    biasSel = 1'b0;
    @(negedge clk);
    check(biasFive == 1'b0, "R9 bias low", {95'd0, biasFive}, 96'd0);

    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule